// File: doc/BRIEF.md
# Instruction Fetch Translation Buffer with Pairwise-Order Replacement

This block is a four-slot, fully associative translation buffer on the instruction-fetch path. Each slot holds a virtual page number, an address-space tag, a physical page number and a nine-bit flag set. The page size is carried in two of the flag bits, so the comparison mask is derived from the flags and is not stored. A lookup presents a virtual address, the current address-space tag and a mode bit. When the mode bit is low, tags are not compared. One cycle later the block reports a hit with its slot number and physical address, a multi-hit, or (after a refill) a miss.

When no slot matches, the block stalls with `lk_busy` and asks a larger unified translation buffer for the page. It holds that request until the unified buffer answers. If the answer carries an entry, the entry goes into the slot picked by a six-bit pairwise recency vector, and the result appears one cycle after the answer. Software can read and write both slot arrays through a small array port, and can read and write the recency vector through a port of its own.

Top module: `ifetch_tlb`

## Requirements
- R1: A slot matches when its valid flag (bit 8) is set and its page number equals the lookup page number under the slot's size mask. The size code is {flag bit 7, flag bit 4}: 00 is 1 KiB, 01 is 4 KiB, 10 is 64 KiB and 11 is 1 MiB. In addition, either the share flag (bit 1) is set, the tags are equal, or `lk_asid_en` is low.
- R2: When a lookup accepted while idle has exactly one matching slot, the cycle after it shows `res_valid`=1, `res_kind`=0 (hit), `res_idx` equal to the slot, and `res_pa` = (PPN & mask) | (VA & ~mask).
- R3: When two or more slots match, the result is `res_kind`=2 (multi-hit) and the recency vector is left unchanged.
- R4: After a hit on slot 0 the recency vector becomes L & 0x07. Slot 1 gives (L & 0x19) | 0x20, slot 2 gives (L & 0x3E) | 0x14, and slot 3 gives L | 0x0B.
- R5: The victim is picked in this priority: slot 0 if (L & 0x38) = 0x38, else slot 1 if (L & 0x26) = 0x06, else slot 2 if (L & 0x15) = 0x01, else slot 3.
- R6: On a miss, `lk_busy` and `ref_req` rise the next cycle and hold, with `ref_va`, `ref_asid` and `ref_asid_en` stable, until `ref_rsp`. On a response with `ref_status`=0, the victim slot takes the page number, tag and PPN as given and the flags ANDed with 0x1DA. The recency vector is updated as for a hit on that slot, and the cycle after the response shows a hit on the victim slot with `lk_busy` low.
- R7: A response with `ref_status`=1 yields `res_kind`=1 (miss), and `ref_status`=2 yields `res_kind`=2. Neither changes any slot or the recency vector.
- R8: Array accesses select the slot with `arr_addr[8:7]`. An address-array access (`arr_sel`=0) reads VPN in bits 31:10, valid in bit 8 and tag in bits 7:0. A write loads those same fields and leaves the other flags unchanged.
- R9: A data-array read (`arr_sel`=1) returns (PPN & 0x1FFFFC00) | flags. A write keeps data bits 28:10 as the PPN and the flags as data & 0x1DA. It forces PPN bits 31:29 to 1 when the kept PPN is 0x1C000000 or above.
- R10: The recency vector resets to 0 and is always visible on `lru_q`. `lru_we` loads it from `lru_wdata` and takes precedence over an update from a hit or refill in the same cycle.
- R11: After reset, every slot is invalid and `lk_busy`, `res_valid` and `ref_req` are 0.
- R12: A lookup request raised while `lk_busy` is high is ignored: it produces no result and leaves the recency vector unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup virtual address |
| lk_asid | input | 8 | Current address-space tag |
| lk_asid_en | input | 1 | 1: compare tags; 0: page number only |
| lk_busy | output | 1 | Refill in progress; lookups ignored |
| res_valid | output | 1 | Result strobe |
| res_kind | output | 2 | 0 hit, 1 miss, 2 multi-hit |
| res_idx | output | 2 | Slot of the hit |
| res_pa | output | 32 | Translated physical address |
| ref_req | output | 1 | Refill request to the unified buffer |
| ref_va | output | 32 | Address of the refill request |
| ref_asid | output | 8 | Tag of the refill request |
| ref_asid_en | output | 1 | Tag-compare mode of the refill request |
| ref_rsp | input | 1 | Unified buffer response strobe |
| ref_status | input | 2 | 0 entry found, 1 miss, 2 multi-hit |
| ref_vpn | input | 22 | Returned page number (VA bits 31:10) |
| ref_ent_asid | input | 8 | Returned tag |
| ref_ppn | input | 32 | Returned physical page base |
| ref_flags | input | 9 | Returned flags |
| arr_we | input | 1 | Array write strobe |
| arr_sel | input | 1 | 0 address array, 1 data array |
| arr_addr | input | 32 | Array access address; bits 8:7 pick the slot |
| arr_wdata | input | 32 | Array write data |
| arr_rdata | output | 32 | Array read data (combinational) |
| lru_we | input | 1 | Recency vector write strobe |
| lru_wdata | input | 6 | Recency vector write value |
| lru_q | output | 6 | Recency vector |

## Verification
The assertions assume that `ref_rsp` arrives only while `ref_req` is high. They also assume the array port never writes the slot being filled in the same cycle as a refill install. The bench meets both assumptions: it answers a refill only after it has seen `ref_req`, and it uses the array port only between lookups. Slot contents are chosen so that every lookup hits exactly the intended slots. Overlaps are created on purpose only for the multi-hit case.

// File: rtl/ifetch_tlb_pkg.sv
package ifetch_tlb_pkg;
    localparam int ADDR_W   = 32;
    localparam int ASID_W   = 8;
    localparam int FLAG_W   = 9;
    localparam int PAGE_LSB = 10;
    localparam int VPN_W    = ADDR_W - PAGE_LSB;
    localparam int ENTRIES  = 4;
    localparam int IDX_W    = $clog2(ENTRIES);
    localparam int LRU_W    = ENTRIES * (ENTRIES - 1) / 2;
    localparam int SLOT_LSB = 7;

    localparam int FB_VALID = 8;
    localparam int FB_SZ_HI = 7;
    localparam int FB_SZ_LO = 4;
    localparam int FB_SHARE = 1;

    localparam logic [FLAG_W-1:0] KEEP_FLAGS = 9'h1DA;
    localparam logic [ADDR_W-1:0] PPN_KEEP   = 32'h1FFF_FC00;
    localparam logic [ADDR_W-1:0] HIGH_AREA  = 32'h1C00_0000;
    localparam logic [ADDR_W-1:0] HIGH_SET   = 32'hE000_0000;

    // Per-slot recency keep masks and set patterns, and victim test masks
    localparam logic [LRU_W-1:0] KEEP0 = 6'h07, SET0 = 6'h00;
    localparam logic [LRU_W-1:0] KEEP1 = 6'h19, SET1 = 6'h20;
    localparam logic [LRU_W-1:0] KEEP2 = 6'h3E, SET2 = 6'h14;
    localparam logic [LRU_W-1:0] KEEP3 = 6'h3F, SET3 = 6'h0B;
    localparam logic [LRU_W-1:0] VTEST0 = 6'h38, VWANT0 = 6'h38;
    localparam logic [LRU_W-1:0] VTEST1 = 6'h26, VWANT1 = 6'h06;
    localparam logic [LRU_W-1:0] VTEST2 = 6'h15, VWANT2 = 6'h01;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [ADDR_W-1:0] ppn;
        logic [FLAG_W-1:0] flags;
    } tlb_entry_t;

    typedef enum logic [1:0] {
        RES_HIT   = 2'd0,
        RES_MISS  = 2'd1,
        RES_MULTI = 2'd2
    } res_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } fill_state_e;

    function automatic logic [VPN_W-1:0] size_mask(input logic [FLAG_W-1:0] f);
        case ({f[FB_SZ_HI], f[FB_SZ_LO]})
            2'b00:   size_mask = {VPN_W{1'b1}};
            2'b01:   size_mask = {VPN_W{1'b1}} << 2;
            2'b10:   size_mask = {VPN_W{1'b1}} << 6;
            default: size_mask = {VPN_W{1'b1}} << 10;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] phys_addr(input logic [ADDR_W-1:0] ppn,
                                                    input logic [FLAG_W-1:0] f,
                                                    input logic [ADDR_W-1:0] va);
        logic [ADDR_W-1:0] m;
        m = {size_mask(f), {PAGE_LSB{1'b0}}};
        phys_addr = (ppn & m) | (va & ~m);
    endfunction

    function automatic logic [ADDR_W-1:0] fix_ppn(input logic [ADDR_W-1:0] wd);
        logic [ADDR_W-1:0] p;
        p = wd & PPN_KEEP;
        fix_ppn = (p >= HIGH_AREA) ? (p | HIGH_SET) : p;
    endfunction

    function automatic logic [LRU_W-1:0] lru_touch(input logic [LRU_W-1:0] l,
                                                   input logic [IDX_W-1:0] idx);
        case (idx)
            2'd0:    lru_touch = (l & KEEP0) | SET0;
            2'd1:    lru_touch = (l & KEEP1) | SET1;
            2'd2:    lru_touch = (l & KEEP2) | SET2;
            default: lru_touch = (l & KEEP3) | SET3;
        endcase
    endfunction

    function automatic logic [IDX_W-1:0] lru_victim(input logic [LRU_W-1:0] l);
        if ((l & VTEST0) == VWANT0)      lru_victim = 2'd0;
        else if ((l & VTEST1) == VWANT1) lru_victim = 2'd1;
        else if ((l & VTEST2) == VWANT2) lru_victim = 2'd2;
        else                             lru_victim = 2'd3;
    endfunction
endpackage

// File: rtl/ifetch_tlb_match.sv
module ifetch_tlb_match
    import ifetch_tlb_pkg::*;
(
    input  tlb_entry_t          ent [ENTRIES],
    input  logic [VPN_W-1:0]    va_vpn,
    input  logic [ASID_W-1:0]   asid,
    input  logic                asid_en,
    output logic [ENTRIES-1:0]  hit_vec,
    output logic [IDX_W-1:0]    hit_idx,
    output logic                any_hit,
    output logic                multi_hit
);
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        logic vpn_eq;
        logic tag_ok;
        assign vpn_eq = ((ent[i].vpn ^ va_vpn) & size_mask(ent[i].flags)) == '0;
        assign tag_ok = !asid_en || ent[i].flags[FB_SHARE] || (ent[i].asid == asid);
        assign hit_vec[i] = ent[i].flags[FB_VALID] && vpn_eq && tag_ok;
    end

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
    end

    assign any_hit   = |hit_vec;
    assign multi_hit = $countones(hit_vec) > 1;
endmodule

// File: rtl/ifetch_tlb_lru.sv
module ifetch_tlb_lru
    import ifetch_tlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_idx,
    input  logic             sw_we,
    input  logic [LRU_W-1:0] sw_data,
    output logic [LRU_W-1:0] lru_q,
    output logic [IDX_W-1:0] victim
);
    always_ff @(posedge clk) begin
        if (rst)           lru_q <= '0;
        else if (sw_we)    lru_q <= sw_data;
        else if (touch_en) lru_q <= lru_touch(lru_q, touch_idx);
    end

    assign victim = lru_victim(lru_q);

    AST_TOUCH_SLOT0: assert property (@(posedge clk) disable iff (rst)
        touch_en && !sw_we && touch_idx == 2'd0 |=> lru_q[5:3] == 3'b000); // R4
    AST_TOUCH_SLOT3: assert property (@(posedge clk) disable iff (rst)
        touch_en && !sw_we && touch_idx == 2'd3 |=> lru_q[0] && lru_q[1] && lru_q[3]); // R4
    AST_SW_WINS: assert property (@(posedge clk) disable iff (rst)
        sw_we |=> lru_q == $past(sw_data)); // R10
endmodule

// File: rtl/ifetch_tlb_store.sv
module ifetch_tlb_store
    import ifetch_tlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              install_en,
    input  logic [IDX_W-1:0]  install_idx,
    input  tlb_entry_t        install_ent,
    input  logic              arr_we,
    input  logic              arr_sel,
    input  logic [IDX_W-1:0]  arr_idx,
    input  logic [ADDR_W-1:0] arr_wdata,
    output logic [ADDR_W-1:0] arr_rdata,
    output tlb_entry_t        ent_q [ENTRIES]
);
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) ent_q[i] <= '0;
        end else begin
            if (arr_we) begin
                if (arr_sel) begin
                    ent_q[arr_idx].ppn   <= fix_ppn(arr_wdata);
                    ent_q[arr_idx].flags <= arr_wdata[FLAG_W-1:0] & KEEP_FLAGS;
                end else begin
                    ent_q[arr_idx].vpn             <= arr_wdata[ADDR_W-1:PAGE_LSB];
                    ent_q[arr_idx].asid            <= arr_wdata[ASID_W-1:0];
                    ent_q[arr_idx].flags[FB_VALID] <= arr_wdata[FB_VALID];
                end
            end
            if (install_en) ent_q[install_idx] <= install_ent;
        end
    end

    always_comb begin
        if (arr_sel)
            arr_rdata = (ent_q[arr_idx].ppn & PPN_KEEP) | ADDR_W'(ent_q[arr_idx].flags);
        else
            arr_rdata = {ent_q[arr_idx].vpn, {PAGE_LSB{1'b0}}}
                      | (ADDR_W'(ent_q[arr_idx].flags[FB_VALID]) << FB_VALID)
                      | ADDR_W'(ent_q[arr_idx].asid);
    end

    AST_HIGH_PPN: assert property (@(posedge clk) disable iff (rst)
        arr_we && arr_sel && !(install_en && install_idx == arr_idx)
        && ((arr_wdata & PPN_KEEP) >= HIGH_AREA)
        |=> ent_q[$past(arr_idx)].ppn[31:29] == 3'b111); // R9
    AST_DATA_FLAGS: assert property (@(posedge clk) disable iff (rst)
        arr_we && arr_sel && !(install_en && install_idx == arr_idx)
        |=> (ent_q[$past(arr_idx)].flags & ~KEEP_FLAGS) == '0); // R9
endmodule

// File: rtl/ifetch_tlb.sv
module ifetch_tlb
    import ifetch_tlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_req,
    input  logic [ADDR_W-1:0] lk_va,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_asid_en,
    output logic              lk_busy,
    output logic              res_valid,
    output logic [1:0]        res_kind,
    output logic [IDX_W-1:0]  res_idx,
    output logic [ADDR_W-1:0] res_pa,
    output logic              ref_req,
    output logic [ADDR_W-1:0] ref_va,
    output logic [ASID_W-1:0] ref_asid,
    output logic              ref_asid_en,
    input  logic              ref_rsp,
    input  logic [1:0]        ref_status,
    input  logic [VPN_W-1:0]  ref_vpn,
    input  logic [ASID_W-1:0] ref_ent_asid,
    input  logic [ADDR_W-1:0] ref_ppn,
    input  logic [FLAG_W-1:0] ref_flags,
    input  logic              arr_we,
    input  logic              arr_sel,
    input  logic [ADDR_W-1:0] arr_addr,
    input  logic [ADDR_W-1:0] arr_wdata,
    output logic [ADDR_W-1:0] arr_rdata,
    input  logic              lru_we,
    input  logic [LRU_W-1:0]  lru_wdata,
    output logic [LRU_W-1:0]  lru_q
);
    fill_state_e       state_q;
    logic [ADDR_W-1:0] pend_va_q;
    logic [ASID_W-1:0] pend_asid_q;
    logic              pend_en_q;
    logic              res_valid_q;
    res_kind_e         res_kind_q;
    logic [IDX_W-1:0]  res_idx_q;
    logic [ADDR_W-1:0] res_pa_q;

    tlb_entry_t          ent [ENTRIES];
    tlb_entry_t          fill_ent;
    logic [ENTRIES-1:0]  hit_vec;
    logic [IDX_W-1:0]    hit_idx;
    logic                any_hit, multi_hit;
    logic [IDX_W-1:0]    victim;
    logic                accept, install_en, touch_en;
    logic [IDX_W-1:0]    touch_idx;
    res_kind_e           rsp_kind;
    logic                unused_arr_bits;

    assign unused_arr_bits = ^{arr_addr[ADDR_W-1:SLOT_LSB+IDX_W], arr_addr[SLOT_LSB-1:0]};

    assign accept     = lk_req && (state_q == ST_IDLE);
    assign rsp_kind   = (ref_status == 2'd0) ? RES_HIT :
                        (ref_status == 2'd2) ? RES_MULTI : RES_MISS;
    assign install_en = (state_q == ST_FILL) && ref_rsp && (rsp_kind == RES_HIT);
    assign touch_en   = (accept && any_hit && !multi_hit) || install_en;
    assign touch_idx  = install_en ? victim : hit_idx;

    always_comb begin
        fill_ent.vpn   = ref_vpn;
        fill_ent.asid  = ref_ent_asid;
        fill_ent.ppn   = ref_ppn;
        fill_ent.flags = ref_flags & KEEP_FLAGS;
    end

    ifetch_tlb_match u_match (
        .ent(ent), .va_vpn(lk_va[ADDR_W-1:PAGE_LSB]), .asid(lk_asid), .asid_en(lk_asid_en),
        .hit_vec(hit_vec), .hit_idx(hit_idx), .any_hit(any_hit), .multi_hit(multi_hit)
    );

    ifetch_tlb_lru u_lru (
        .clk(clk), .rst(rst), .touch_en(touch_en), .touch_idx(touch_idx),
        .sw_we(lru_we), .sw_data(lru_wdata), .lru_q(lru_q), .victim(victim)
    );

    ifetch_tlb_store u_store (
        .clk(clk), .rst(rst), .install_en(install_en), .install_idx(victim),
        .install_ent(fill_ent), .arr_we(arr_we), .arr_sel(arr_sel),
        .arr_idx(arr_addr[SLOT_LSB +: IDX_W]), .arr_wdata(arr_wdata),
        .arr_rdata(arr_rdata), .ent_q(ent)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            pend_va_q   <= '0;
            pend_asid_q <= '0;
            pend_en_q   <= 1'b0;
            res_valid_q <= 1'b0;
            res_kind_q  <= RES_HIT;
            res_idx_q   <= '0;
            res_pa_q    <= '0;
        end else begin
            res_valid_q <= 1'b0;
            if (accept) begin
                if (multi_hit) begin
                    res_valid_q <= 1'b1;
                    res_kind_q  <= RES_MULTI;
                end else if (any_hit) begin
                    res_valid_q <= 1'b1;
                    res_kind_q  <= RES_HIT;
                    res_idx_q   <= hit_idx;
                    res_pa_q    <= phys_addr(ent[hit_idx].ppn, ent[hit_idx].flags, lk_va);
                end else begin
                    state_q     <= ST_FILL;
                    pend_va_q   <= lk_va;
                    pend_asid_q <= lk_asid;
                    pend_en_q   <= lk_asid_en;
                end
            end else if (state_q == ST_FILL && ref_rsp) begin
                state_q     <= ST_IDLE;
                res_valid_q <= 1'b1;
                res_kind_q  <= rsp_kind;
                res_idx_q   <= victim;
                res_pa_q    <= phys_addr(ref_ppn, fill_ent.flags, pend_va_q);
            end
        end
    end

    assign lk_busy     = (state_q == ST_FILL);
    assign ref_req     = (state_q == ST_FILL);
    assign ref_va      = pend_va_q;
    assign ref_asid    = pend_asid_q;
    assign ref_asid_en = pend_en_q;
    assign res_valid   = res_valid_q;
    assign res_kind    = res_kind_q;
    assign res_idx     = res_idx_q;
    assign res_pa      = res_pa_q;

    AST_FILL_LATENCY: assert property (@(posedge clk) disable iff (rst)
        ref_req && ref_rsp |=> res_valid && !lk_busy); // R6
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        ref_req && !ref_rsp |=> ref_req && $stable(ref_va) && $stable(ref_asid)); // R6
    AST_HIT_VALID: assert property (@(posedge clk) disable iff (rst)
        res_valid && res_kind == 2'd0 |-> ent[res_idx].flags[FB_VALID]); // R2
    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (rst)
        lk_busy && !ref_rsp |=> !res_valid); // R12
endmodule

// File: tb/ifetch_tlb_test.sv
module ifetch_tlb_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_req = 0, lk_asid_en = 0;
    logic [31:0] lk_va = 0;
    logic [7:0]  lk_asid = 0;
    logic        lk_busy, res_valid;
    logic [1:0]  res_kind, res_idx;
    logic [31:0] res_pa, ref_va;
    logic        ref_req, ref_asid_en;
    logic [7:0]  ref_asid;
    logic        ref_rsp = 0;
    logic [1:0]  ref_status = 0;
    logic [21:0] ref_vpn = 0;
    logic [7:0]  ref_ent_asid = 0;
    logic [31:0] ref_ppn = 0;
    logic [8:0]  ref_flags = 0;
    logic        arr_we = 0, arr_sel = 0;
    logic [31:0] arr_addr = 0, arr_wdata = 0, arr_rdata;
    logic        lru_we = 0;
    logic [5:0]  lru_wdata = 0, lru_q;

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ifetch_tlb uut (.*);

    typedef struct packed {
        logic [31:0] va; logic [7:0] asid; logic en;
        logic [1:0] idx; logic [31:0] pa; logic [5:0] lru;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{32'h0040_0ABC, 8'h05, 1'b1, 2'd0, 32'h0C00_0ABC, 6'h00},
        '{32'h0080_03FF, 8'h33, 1'b1, 2'd1, 32'h0D00_03FF, 6'h20},
        '{32'h0100_FFFC, 8'h05, 1'b1, 2'd2, 32'h0E00_FFFC, 6'h34},
        '{32'h020A_BCDE, 8'h09, 1'b1, 2'd3, 32'hFC1A_BCDE, 6'h3F},
        '{32'h0040_0010, 8'h06, 1'b0, 2'd0, 32'h0C00_0010, 6'h07},
        '{32'h0200_0004, 8'h05, 1'b0, 2'd3, 32'hFC10_0004, 6'h0F}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk); #1;
    endtask

    task automatic arr_write(input logic sel, input int slot, input logic [31:0] d);
        arr_we = 1; arr_sel = sel; arr_addr = 32'(slot) << 7; arr_wdata = d;
        tick();
        arr_we = 0;
    endtask

    task automatic arr_read(input logic sel, input int slot, output logic [31:0] d);
        arr_sel = sel; arr_addr = (32'(slot) << 7) | 32'h7C;
        #1 d = arr_rdata;
    endtask

    task automatic lookup(input logic [31:0] va, input logic [7:0] asid, input logic en);
        lk_va = va; lk_asid = asid; lk_asid_en = en; lk_req = 1;
        tick();
        lk_req = 0;
    endtask

    task automatic respond(input logic [1:0] st, input logic [21:0] vpn, input logic [7:0] asid,
                           input logic [31:0] ppn, input logic [8:0] fl);
        ref_status = st; ref_vpn = vpn; ref_ent_asid = asid; ref_ppn = ppn; ref_flags = fl;
        ref_rsp = 1;
        tick();
        ref_rsp = 0;
    endtask

    task automatic set_lru(input logic [5:0] v);
        lru_we = 1; lru_wdata = v;
        tick();
        lru_we = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R11: reset state
        check("R11 busy", 32'(lk_busy), 0);
        check("R11 res_valid", 32'(res_valid), 0);
        check("R11 ref_req", 32'(ref_req), 0);
        check("R10 lru reset", 32'(lru_q), 0);
        arr_read(0, 2, d); check("R11 slot invalid", d, 0);

        // Load slots: data first, then address (address write keeps other flags)
        arr_write(1, 0, 32'h0C00_0110); arr_write(0, 0, 32'h0040_0105);
        arr_write(1, 1, 32'h0D00_0102); arr_write(0, 1, 32'h0080_0107);
        arr_write(1, 2, 32'h0E00_0180); arr_write(0, 2, 32'h0100_0105);
        arr_write(1, 3, 32'hFC10_01B5); arr_write(0, 3, 32'h0200_0109);
        arr_read(1, 3, d); check("R9 data read masks flags/ppn", d, 32'h1C10_0190);
        arr_read(0, 3, d); check("R8 address read", d, 32'h0200_0109);
        arr_read(1, 0, d); check("R8 address write keeps flags", d, 32'h0C00_0110);

        // Table walk: single hits across sizes and modes (R1 R2 R4)
        foreach (VECS[i]) begin
            lookup(VECS[i].va, VECS[i].asid, VECS[i].en);
            check("R2 res_valid", 32'(res_valid), 1);
            check("R2 kind hit", 32'(res_kind), 0);
            check("R1 hit slot", 32'(res_idx), 32'(VECS[i].idx));
            check("R2 pa", res_pa, VECS[i].pa);
            check("R4 lru", 32'(lru_q), 32'(VECS[i].lru));
        end

        // R1/R6: tag mismatch misses, refill into victim slot 1 (lru 0x0F)
        lookup(32'h0040_0010, 8'h06, 1'b1);
        check("R6 busy", 32'(lk_busy), 1);
        check("R6 ref_req", 32'(ref_req), 1);
        check("R6 ref_va", ref_va, 32'h0040_0010);
        check("R6 ref_asid", 32'(ref_asid), 32'h06);
        check("R1 no result on tag miss", 32'(res_valid), 0);
        tick();
        // R12: request while busy is ignored
        lookup(32'h020A_BCDE, 8'h09, 1'b1);
        check("R12 no result", 32'(res_valid), 0);
        check("R12 lru unchanged", 32'(lru_q), 32'h0F);
        check("R6 ref_va held", ref_va, 32'h0040_0010);
        respond(2'd0, 22'h0_1000, 8'h06, 32'h0C40_0000, 9'h1FF);
        check("R6 res after fill", 32'(res_valid), 1);
        check("R6 kind hit", 32'(res_kind), 0);
        check("R5 victim slot 1", 32'(res_idx), 1);
        check("R6 pa", res_pa, 32'h0C40_0010);
        check("R6 busy released", 32'(lk_busy), 0);
        check("R6 lru", 32'(lru_q), 32'h29);
        arr_read(1, 1, d); check("R6 installed flags", d, 32'h0C40_01DA);
        arr_read(0, 1, d); check("R6 installed tag", d, 32'h0040_0106);

        // R3: overlapping slots 0 and 1
        lookup(32'h0040_0020, 8'h05, 1'b1);
        check("R3 kind multi", 32'(res_kind), 2);
        check("R3 res_valid", 32'(res_valid), 1);
        check("R3 lru unchanged", 32'(lru_q), 32'h29);

        // R7: unified miss and multi
        lookup(32'h3000_0000, 8'h01, 1'b1);
        respond(2'd1, 22'h0, 8'h0, 32'h0, 9'h1FF);
        check("R7 kind miss", 32'(res_kind), 1);
        check("R7 lru unchanged", 32'(lru_q), 32'h29);
        arr_read(0, 2, d); check("R7 victim untouched", d, 32'h0100_0105);
        lookup(32'h3000_0000, 8'h01, 1'b1);
        respond(2'd2, 22'h0, 8'h0, 32'h0, 9'h1FF);
        check("R7 kind multi", 32'(res_kind), 2);

        // R10: software write beats a same-cycle hit update
        lru_we = 1; lru_wdata = 6'h15;
        lookup(32'h020A_BCDE, 8'h09, 1'b1);
        lru_we = 0;
        check("R10 hit slot 3", 32'(res_idx), 3);
        check("R10 sw write wins", 32'(lru_q), 32'h15);

        // R5: victim priority
        set_lru(6'h38);
        lookup(32'h3100_0000, 8'h01, 1'b1);
        respond(2'd0, 22'h0C_4000, 8'h01, 32'h0010_0000, 9'h110);
        check("R5 victim slot 0", 32'(res_idx), 0);
        check("R5 pa", res_pa, 32'h0010_0000);
        check("R5 lru after slot0", 32'(lru_q), 32'h00);
        set_lru(6'h00);
        lookup(32'h3200_0000, 8'h01, 1'b1);
        respond(2'd0, 22'h0C_8000, 8'h01, 32'h0020_0000, 9'h100);
        check("R5 victim slot 3", 32'(res_idx), 3);
        check("R5 lru after slot3", 32'(lru_q), 32'h0B);
        set_lru(6'h01);
        lookup(32'h3300_0000, 8'h01, 1'b1);
        respond(2'd0, 22'h0C_C000, 8'h01, 32'h0030_0000, 9'h100);
        check("R5 victim slot 2", 32'(res_idx), 2);
        check("R5 lru after slot2", 32'(lru_q), 32'h14);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule